// File: doc/BRIEF.md
# Completion Counter Interrupt Coalescer

This block keeps a running count of finished instructions that requested a completion interrupt, and turns that count into a single coalesced interrupt. The interrupt is raised once enough completions have piled up or once a scaled time window has passed with completions still pending. Software consumes completions and then writes back how many it handled. The block subtracts that number and evaluates the interrupt condition again on the following cycle. If completions arrived while software was busy, the interrupt comes back at once.

Completions arrive as a one-cycle pulse carrying the instruction's first control word. Bit 16 of that word is the done-interrupt flag. Completions are always accepted and there is no back-pressure. Configuration and acknowledgement use plain write strobes with their data. The current count and the settings are visible on output ports, so a register front end can return them on reads. The interrupt output is a level.

Top module: `cmpl_coalescer`

## Requirements
- R1: After reset, the done count, the count threshold, the time setting and the enable are all zero, and irq is low.
- R2: The count rises by one on a cycle where cmpl_valid is high and bit 16 of cmpl_word0 is 1. With bit 16 at 0, the count does not change, whatever the other 63 bits hold.
- R3: An ack_we write subtracts ack_val from the count. A completion and an acknowledgement in the same cycle both apply, giving count + 1 − ack_val. The result saturates at zero.
- R4: While the count is zero, irq is low and the time window is held at zero. A completion that follows a long idle stretch must still wait the full window.
- R5: irq is high when enabled, the count is nonzero and the count is at least num_wait. A num_wait of 0 acts as 1.
- R6: irq is high when enabled and the count has been nonzero for time_wait × 1024 clock edges since the window last restarted. A time_wait of 0 switches the time path off.
- R7: Any ack_we write, including one with a value of 0, restarts the time window. On the cycle after the write, irq reflects the new count, so it stays or comes back high if the remainder still meets num_wait.
- R8: A cnt_we write loads cnt_val into the count and restarts the time window. It takes priority over a completion or an acknowledgement in the same cycle.
- R9: A pulse on ena_set sets the enable and a pulse on ena_clr clears it. If both arrive in the same cycle, clear wins. While the enable is clear, irq is low, but counting and timing continue, so setting the enable again raises irq at once if the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | One-cycle pulse: an instruction finished |
| cmpl_word0 | input | 64 | First control word of the finished instruction; bit 16 is the done-interrupt flag |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_val | input | 20 | Number of completions consumed |
| cnt_we | input | 1 | Diagnostic count write strobe |
| cnt_val | input | 20 | Value loaded into the count |
| wait_we | input | 1 | Coalescing settings write strobe |
| wait_num | input | 20 | Count threshold (0 acts as 1) |
| wait_time | input | 16 | Time threshold in units of 1024 cycles (0 = off) |
| ena_set | input | 1 | Set the interrupt enable |
| ena_clr | input | 1 | Clear the interrupt enable |
| done_count | output | 20 | Current done count (also the acknowledge read value) |
| num_wait_q | output | 20 | Stored count threshold |
| time_wait_q | output | 16 | Stored time threshold |
| irq_ena | output | 1 | Stored interrupt enable |
| irq | output | 1 | Coalesced interrupt level |

## Verification
Two situations are the hardest to reach from the ports. The first is the exact edge on which the time window expires. The second is the race in which software acknowledges only part of the count while more completions are still pending. For the first, the stimulus puts one completion in flight with a threshold the count cannot reach, then counts clock edges. It samples irq on the edge just before time_wait × 1024 and again on that edge. It repeats this after a long idle stretch, after a zero-valued acknowledgement and after a diagnostic load, each of which must move the window back to zero. For the race, the stimulus builds the count above num_wait and acknowledges part of it. It then checks that irq is high again on the very next cycle, with no wait for the timer.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Default geometry of the coalescer
  localparam int unsigned DEF_CNT_W         = 20;
  localparam int unsigned DEF_TW_W          = 16;
  localparam int unsigned DEF_PRESCALE_LOG2 = 10;
  localparam int unsigned DEF_WORD_W        = 64;
  localparam int unsigned DEF_FLAG_BIT      = 16;

  // How the done count moves in a cycle
  typedef enum logic [1:0] {
    CNT_KEEP = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cc_count_unit.sv
module cc_count_unit
  import cc_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             ack_we,
  input  logic [CNT_W-1:0] ack_val,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             is_zero
);
  localparam int unsigned EXT_W = CNT_W + 1;

  cnt_op_e          op;
  logic [EXT_W-1:0] grown;
  logic [EXT_W-1:0] take;
  logic [CNT_W-1:0] stepped;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    if (load_we)             op = CNT_LOAD;
    else if (bump || ack_we) op = CNT_STEP;
    else                     op = CNT_KEEP;
  end

  // Completion first, then acknowledge, with a floor at zero
  always_comb begin
    grown = {1'b0, count_q} + {{CNT_W{1'b0}}, bump};
    take  = ack_we ? {1'b0, ack_val} : '0;
    if (take > grown) stepped = '0;
    else              stepped = CNT_W'(grown - take);
  end

  always_comb begin
    unique case (op)
      CNT_LOAD: count_d = load_val;
      CNT_STEP: count_d = stepped;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign is_zero = (count_q == '0);
endmodule

// File: rtl/cc_hold_timer.sv
module cc_hold_timer #(
  parameter int unsigned TMR_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  output logic [TMR_W-1:0] tmr_q
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [TMR_W-1:0] tmr_d;

  // Held at zero while nothing is pending, cleared on restart, saturates
  always_comb begin
    if (hold || restart)      tmr_d = '0;
    else if (tmr_q != TMR_MAX) tmr_d = tmr_q + TMR_W'(1);
    else                      tmr_d = tmr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/cc_fire_eval.sv
module cc_fire_eval #(
  parameter int unsigned CNT_W         = 20,
  parameter int unsigned TW_W          = 16,
  parameter int unsigned PRESCALE_LOG2 = 10,
  parameter int unsigned TMR_W         = TW_W + PRESCALE_LOG2
) (
  input  logic [CNT_W-1:0] count,
  input  logic [TMR_W-1:0] tmr,
  input  logic [CNT_W-1:0] num_wait,
  input  logic [TW_W-1:0]  time_wait,
  output logic             count_hit,
  output logic             time_hit,
  output logic             fire
);
  logic [CNT_W-1:0] num_eff;
  logic [TMR_W-1:0] time_limit;

  // A zero threshold behaves as one
  assign num_eff = (num_wait == '0) ? CNT_W'(1) : num_wait;

  generate
    if (PRESCALE_LOG2 == 0) begin : g_unscaled
      assign time_limit = time_wait;
    end else begin : g_scaled
      assign time_limit = {time_wait, {PRESCALE_LOG2{1'b0}}};
    end
  endgenerate

  assign count_hit = (count >= num_eff);
  assign time_hit  = (time_wait != '0) && (tmr >= time_limit);
  assign fire      = (count != '0) && (count_hit || time_hit);
endmodule

// File: rtl/cmpl_coalescer.sv
module cmpl_coalescer
  import cc_pkg::*;
#(
  parameter int unsigned CNT_W         = DEF_CNT_W,
  parameter int unsigned TW_W          = DEF_TW_W,
  parameter int unsigned PRESCALE_LOG2 = DEF_PRESCALE_LOG2,
  parameter int unsigned WORD_W        = DEF_WORD_W,
  parameter int unsigned FLAG_BIT      = DEF_FLAG_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_valid,
  input  logic [WORD_W-1:0] cmpl_word0,
  input  logic              ack_we,
  input  logic [CNT_W-1:0]  ack_val,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              wait_we,
  input  logic [CNT_W-1:0]  wait_num,
  input  logic [TW_W-1:0]   wait_time,
  input  logic              ena_set,
  input  logic              ena_clr,
  output logic [CNT_W-1:0]  done_count,
  output logic [CNT_W-1:0]  num_wait_q,
  output logic [TW_W-1:0]   time_wait_q,
  output logic              irq_ena,
  output logic              irq
);
  localparam int unsigned TMR_W = TW_W + PRESCALE_LOG2;

  logic             bump;
  logic             cnt_zero;
  logic             tmr_restart;
  logic [TMR_W-1:0] tmr;
  logic             count_hit;
  logic             time_hit;
  logic             fire;

  assign bump        = cmpl_valid && cmpl_word0[FLAG_BIT];
  assign tmr_restart = ack_we || cnt_we;

  // Coalescing settings
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_wait_q  <= '0;
      time_wait_q <= '0;
    end else if (wait_we) begin
      num_wait_q  <= wait_num;
      time_wait_q <= wait_time;
    end
  end

  // Interrupt enable, clear has priority
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_ena <= 1'b0;
    else if (ena_clr) irq_ena <= 1'b0;
    else if (ena_set) irq_ena <= 1'b1;
  end

  cc_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .bump     (bump),
    .ack_we   (ack_we),
    .ack_val  (ack_val),
    .load_we  (cnt_we),
    .load_val (cnt_val),
    .count_q  (done_count),
    .is_zero  (cnt_zero)
  );

  cc_hold_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (cnt_zero),
    .restart (tmr_restart),
    .tmr_q   (tmr)
  );

  cc_fire_eval #(
    .CNT_W         (CNT_W),
    .TW_W          (TW_W),
    .PRESCALE_LOG2 (PRESCALE_LOG2),
    .TMR_W         (TMR_W)
  ) u_fire (
    .count     (done_count),
    .tmr       (tmr),
    .num_wait  (num_wait_q),
    .time_wait (time_wait_q),
    .count_hit (count_hit),
    .time_hit  (time_hit),
    .fire      (fire)
  );

  assign irq = fire && irq_ena;
endmodule

// File: rtl/cmpl_coalescer_chk.sv
module cmpl_coalescer_chk #(
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned TW_W     = 16,
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned FLAG_BIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmpl_valid,
  input logic [WORD_W-1:0] cmpl_word0,
  input logic              ack_we,
  input logic              cnt_we,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              ena_set,
  input logic              ena_clr,
  input logic [CNT_W-1:0]  done_count,
  input logic [CNT_W-1:0]  num_wait_q,
  input logic              irq_ena,
  input logic              irq
);
  logic [CNT_W-1:0] thr;
  assign thr = (num_wait_q == '0) ? CNT_W'(1) : num_wait_q;

  p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_word0[FLAG_BIT] && !ack_we && !cnt_we) |=> $stable(done_count));

  p_ack_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !cnt_we) |=> ({1'b0, done_count} <= {1'b0, $past(done_count)} + (CNT_W+1)'(1)));

  p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_count == '0) |-> !irq);

  p_count_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ena && done_count != '0 && done_count >= thr) |-> irq);

  p_diag_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (done_count == $past(cnt_val)));

  p_ena_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ena |-> !irq);

  p_ena_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ena_clr |=> !irq_ena);
endmodule

bind cmpl_coalescer cmpl_coalescer_chk #(
  .CNT_W    (CNT_W),
  .TW_W     (TW_W),
  .WORD_W   (WORD_W),
  .FLAG_BIT (FLAG_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmpl_valid (cmpl_valid),
  .cmpl_word0 (cmpl_word0),
  .ack_we     (ack_we),
  .cnt_we     (cnt_we),
  .cnt_val    (cnt_val),
  .ena_set    (ena_set),
  .ena_clr    (ena_clr),
  .done_count (done_count),
  .num_wait_q (num_wait_q),
  .irq_ena    (irq_ena),
  .irq        (irq)
);

// File: tb/cmpl_coalescer_tb.sv
`timescale 1ns/1ps
module cmpl_coalescer_tb;
  localparam int CW = 20;
  localparam int TW = 16;
  localparam logic [63:0] W_ON  = 64'hA5A5_0000_0001_1234;
  localparam logic [63:0] W_OFF = 64'hFFFF_FFFF_FFFE_FFFF;

  typedef struct packed {
    logic          cv;
    logic          fl;
    logic          aw;
    logic [CW-1:0] av;
    logic [CW-1:0] ec;
    logic          ei;
  } vec_t;

  // num_wait = 3, time_wait = 0, enabled
  localparam vec_t VECS [11] = '{
    '{1'b1, 1'b1, 1'b0, 20'd0, 20'd1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 20'd0, 20'd1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 20'd0, 20'd2, 1'b0},
    '{1'b1, 1'b1, 1'b0, 20'd0, 20'd3, 1'b1},
    '{1'b0, 1'b0, 1'b0, 20'd0, 20'd3, 1'b1},
    '{1'b0, 1'b0, 1'b1, 20'd1, 20'd2, 1'b0},
    '{1'b1, 1'b1, 1'b1, 20'd1, 20'd2, 1'b0},
    '{1'b1, 1'b1, 1'b0, 20'd0, 20'd3, 1'b1},
    '{1'b0, 1'b0, 1'b1, 20'd5, 20'd0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 20'd0, 20'd1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 20'd1, 20'd0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmpl_valid = 1'b0;
  logic [63:0]   cmpl_word0 = '0;
  logic          ack_we = 1'b0;
  logic [CW-1:0] ack_val = '0;
  logic          cnt_we = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          wait_we = 1'b0;
  logic [CW-1:0] wait_num = '0;
  logic [TW-1:0] wait_time = '0;
  logic          ena_set = 1'b0;
  logic          ena_clr = 1'b0;
  logic [CW-1:0] done_count;
  logic [CW-1:0] num_wait_q;
  logic [TW-1:0] time_wait_q;
  logic          irq_ena;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmpl_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_word0(cmpl_word0),
    .ack_we(ack_we), .ack_val(ack_val), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .wait_we(wait_we), .wait_num(wait_num), .wait_time(wait_time),
    .ena_set(ena_set), .ena_clr(ena_clr), .done_count(done_count),
    .num_wait_q(num_wait_q), .time_wait_q(time_wait_q), .irq_ena(irq_ena), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic complete(input logic [63:0] w);
    cmpl_valid = 1'b1; cmpl_word0 = w; tick(1); cmpl_valid = 1'b0; cmpl_word0 = '0;
  endtask

  task automatic ack(input logic [CW-1:0] v);
    ack_we = 1'b1; ack_val = v; tick(1); ack_we = 1'b0; ack_val = '0;
  endtask

  task automatic set_wait(input logic [CW-1:0] n, input logic [TW-1:0] t);
    wait_we = 1'b1; wait_num = n; wait_time = t; tick(1); wait_we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 count", 32'(done_count), 0);
    chk("R1 num_wait", 32'(num_wait_q), 0);
    chk("R1 time_wait", 32'(time_wait_q), 0);
    chk("R1 ena", 32'(irq_ena), 0);
    chk("R1 irq", 32'(irq), 0);

    set_wait(20'd3, 16'd0);
    ena_set = 1'b1; tick(1); ena_set = 1'b0;

    // Vector walk: R2 flag decode, R3 ack arithmetic, R5 count threshold
    foreach (VECS[i]) begin
      cmpl_valid = VECS[i].cv;
      cmpl_word0 = VECS[i].fl ? W_ON : W_OFF;
      ack_we     = VECS[i].aw;
      ack_val    = VECS[i].av;
      tick(1);
      chk("R2/R3 vector count", 32'(done_count), 32'(VECS[i].ec));
      chk("R5 vector irq", 32'(irq), 32'(VECS[i].ei));
    end
    cmpl_valid = 1'b0; cmpl_word0 = '0; ack_we = 1'b0; ack_val = '0;

    // R5: num_wait 0 acts as 1
    set_wait(20'd0, 16'd0);
    complete(W_ON);
    chk("R5 zero threshold irq", 32'(irq), 1);
    ack(20'd1);

    // R9: enable control, counting continues while disabled
    ena_clr = 1'b1; tick(1); ena_clr = 1'b0;
    chk("R9 cleared", 32'(irq_ena), 0);
    complete(W_ON);
    chk("R9 still counts", 32'(done_count), 1);
    chk("R9 masked irq", 32'(irq), 0);
    ena_set = 1'b1; ena_clr = 1'b1; tick(1); ena_set = 1'b0; ena_clr = 1'b0;
    chk("R9 clear wins", 32'(irq_ena), 0);
    ena_set = 1'b1; tick(1); ena_set = 1'b0;
    chk("R9 set raises irq", 32'(irq), 1);
    ack(20'd1);

    // R4 + R6: idle with zero count holds the window, then exact expiry
    set_wait(20'd100, 16'd1);
    tick(2000);
    chk("R4 idle irq", 32'(irq), 0);
    complete(W_ON);
    tick(1023);
    chk("R4/R6 before window", 32'(irq), 0);
    tick(1);
    chk("R6 window reached", 32'(irq), 1);

    // R7: zero-valued ack restarts the window
    ack(20'd0);
    chk("R7 count kept", 32'(done_count), 1);
    chk("R7 irq drops", 32'(irq), 0);
    tick(1023);
    chk("R7 before window", 32'(irq), 0);
    tick(1);
    chk("R7 window again", 32'(irq), 1);

    // R8: diagnostic load beats a same-cycle completion and restarts the window
    cnt_we = 1'b1; cnt_val = 20'd5; cmpl_valid = 1'b1; cmpl_word0 = W_ON;
    tick(1);
    cnt_we = 1'b0; cnt_val = '0; cmpl_valid = 1'b0; cmpl_word0 = '0;
    chk("R8 loaded", 32'(done_count), 5);
    chk("R8 irq restart", 32'(irq), 0);
    tick(1023);
    chk("R8 before window", 32'(irq), 0);
    tick(1);
    chk("R8 window", 32'(irq), 1);
    cnt_we = 1'b1; tick(1); cnt_we = 1'b0;
    chk("R8 cleared", 32'(done_count), 0);

    // R6: time_wait 0 disables the time path
    set_wait(20'd100, 16'd0);
    complete(W_ON);
    tick(3000);
    chk("R6 time off irq", 32'(irq), 0);
    chk("R6 time off count", 32'(done_count), 1);
    ack(20'd1);

    // R7: partial ack with remainder above threshold re-fires at once
    set_wait(20'd2, 16'd0);
    repeat (4) complete(W_ON);
    chk("R7 count built", 32'(done_count), 4);
    chk("R7 irq before ack", 32'(irq), 1);
    ack(20'd1);
    chk("R7 remainder", 32'(done_count), 3);
    chk("R7 immediate refire", 32'(irq), 1);
    ack(20'd2);
    chk("R7 below threshold", 32'(irq), 0);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule